// File: doc/BRIEF.md
# Branch Clock Gate with Voting and Status

This block gates one consumer's branch of a root clock. The branch runs whenever at least one requester asks for it. A requester can be the software enable bit, any master's bit in a vote register, or a hardware request input, which counts only when the control register has handed the gate to hardware control. An optional integer post-divider swallows root pulses so the branch runs at a fraction of the root rate.

The gate enable is captured by a latch that is transparent only while the root clock is low, so the output never changes level while the root is high. Software learns the gate state from a four-bit status field in the control register's top nibble. The field passes through a two-flop synchronizer, so it trails the request by two root cycles, and software polls it until the on or off code appears. A separate block-reset register drives a reset line toward the downstream logic.

Register writes are single-cycle strobes that carry a select and a 32-bit data word. The control and vote registers are read back on dedicated outputs.

Top module: `branch_gate`

## Requirements
- R1: After reset the control register, vote register and block reset all read 0, the status field reads 0x8, and the gated clock is low.
- R2: With select 0, a write sets control bit 0 as the software enable. While it is 1, the gated clock runs on the next root cycle.
- R3: With select 1, a write loads the vote register, one bit per master. Any set bit runs the gated clock, and clearing every bit stops it.
- R4: Control bit 1 selects hardware control. While it is 1, the input hwReq high runs the gate and hwReq low stops it, unless another requester is active. While it is 0, hwReq has no effect.
- R5: Status bits [31:28] of the control readback read 0x8 when the gate is off and 0x0 when it is on through the enable bit or a vote. They read 0x2 when it is on only through hardware control. The field shows the request state as it stood two root cycles earlier.
- R6: Control bits [24:16] hold a post-divider value d. The gated clock passes one root pulse and then swallows d pulses, repeating, so d = 0 passes the root clock unchanged.
- R7: A control write whose divider field exceeds MAXDIV leaves the stored divider unchanged, while bits 0 and 1 still take the written values.
- R8: With select 2, a write sets blkRstOut to data bit 0. It holds that value until the next such write.
- R9: The gated clock is never high while the root clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Root clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Register select: 0 control, 1 vote, 2 block reset |
| wrData | input | 32 | Write data |
| hwReq | input | 1 | Hardware clock request, used under hardware control |
| gclkOut | output | 1 | Gated and optionally divided branch clock |
| ctrlRd | output | 32 | Control readback with status in [31:28] |
| voteRd | output | NMAST | Vote register readback |
| blkRstOut | output | 1 | Reset toward the downstream block |

## Verification
The assertions assume that wrSel never takes the unused value 3 while wrEn is high. They also assume that every input changes only while the root clock is low, away from the rising edge. The bench drives all stimulus on the falling edge and uses only the three defined selects. It checks the gated clock in the middle of both clock phases, so a pulse that appears in the low phase is caught. The reference model tracks a two-cycle status history and a swallow counter in plain integers.

// File: rtl/branch_gate_pkg.sv
package branch_gate_pkg;
  localparam int DIV_W   = 9;
  localparam int DIV_LSB = 16;
  localparam int STAT_LSB = 28;

  localparam logic [3:0] STAT_ON    = 4'h0;
  localparam logic [3:0] STAT_HWON  = 4'h2;
  localparam logic [3:0] STAT_OFF   = 4'h8;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_VOTE = 2'd1;
  localparam logic [1:0] SEL_BRST = 2'd2;

  typedef struct packed {
    logic             run;
    logic [DIV_W-1:0] div;
  } gate_cmd_t;
endpackage

// File: rtl/branch_gate_ctrl.sv
module branch_gate_ctrl
  import branch_gate_pkg::*;
#(
  parameter int NMAST  = 4,
  parameter int MAXDIV = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrSel,
  input  logic [31:0]      wrData,
  input  logic             hwReq,
  output gate_cmd_t        cmd,
  output logic [31:0]      ctrlRd,
  output logic [NMAST-1:0] voteRd,
  output logic             blkRst
);
  logic             swEn, hwCtl;
  logic [DIV_W-1:0] divQ;
  logic [NMAST-1:0] voteQ;
  logic             brstQ;
  logic [DIV_W-1:0] divIn;
  logic             softOn, hwOn, reqOn;
  logic [1:0]       syncA, syncB;   // {on, hwOnly}
  logic [3:0]       statCode;

  assign divIn  = wrData[DIV_LSB +: DIV_W];
  assign softOn = swEn | (|voteQ);
  assign hwOn   = hwCtl & hwReq;
  assign reqOn  = softOn | hwOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swEn  <= 1'b0;
      hwCtl <= 1'b0;
      divQ  <= '0;
      voteQ <= '0;
      brstQ <= 1'b0;
    end else if (wrEn) begin
      case (wrSel)
        SEL_CTRL: begin
          swEn  <= wrData[0];
          hwCtl <= wrData[1];
          if (int'(divIn) <= MAXDIV) divQ <= divIn;
        end
        SEL_VOTE: voteQ <= wrData[NMAST-1:0];
        SEL_BRST: brstQ <= wrData[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 2'b00;
      syncB <= 2'b00;
    end else begin
      syncA <= {reqOn, hwOn & ~softOn};
      syncB <= syncA;
    end
  end

  always_comb begin
    if (!syncB[1])     statCode = STAT_OFF;
    else if (syncB[0]) statCode = STAT_HWON;
    else               statCode = STAT_ON;
  end

  always_comb begin
    ctrlRd = '0;
    ctrlRd[0] = swEn;
    ctrlRd[1] = hwCtl;
    ctrlRd[DIV_LSB +: DIV_W] = divQ;
    ctrlRd[STAT_LSB +: 4] = statCode;
  end

  assign voteRd  = voteQ;
  assign blkRst  = brstQ;
  assign cmd.run = reqOn;
  assign cmd.div = divQ;
endmodule

// File: rtl/branch_gate_dp.sv
module branch_gate_dp
  import branch_gate_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  gate_cmd_t cmd,
  output logic      gclk
);
  logic [DIV_W-1:0] swallowCnt;
  logic             fire;
  logic             enLat;

  assign fire = cmd.run & (swallowCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   swallowCnt <= '0;
    else if (!cmd.run)           swallowCnt <= '0;
    else if (swallowCnt >= cmd.div) swallowCnt <= '0;
    else                         swallowCnt <= swallowCnt + 1'b1;
  end

  always_latch begin
    if (!rstN)     enLat = 1'b0;
    else if (!clk) enLat = fire;
  end

  assign gclk = clk & enLat;
endmodule

// File: rtl/branch_gate.sv
module branch_gate
  import branch_gate_pkg::*;
#(
  parameter int NMAST  = 4,
  parameter int MAXDIV = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrSel,
  input  logic [31:0]      wrData,
  input  logic             hwReq,
  output logic             gclkOut,
  output logic [31:0]      ctrlRd,
  output logic [NMAST-1:0] voteRd,
  output logic             blkRstOut
);
  gate_cmd_t cmd;

  branch_gate_ctrl #(.NMAST(NMAST), .MAXDIV(MAXDIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .hwReq(hwReq), .cmd(cmd), .ctrlRd(ctrlRd), .voteRd(voteRd),
    .blkRst(blkRstOut)
  );

  branch_gate_dp u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .gclk(gclkOut)
  );
endmodule

// File: rtl/branch_gate_chk.sv
module branch_gate_chk #(
  parameter int NMAST  = 4,
  parameter int MAXDIV = 15
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [1:0]       wrSel,
  input logic [31:0]      wrData,
  input logic [31:0]      ctrlRd,
  input logic [NMAST-1:0] voteRd,
  input logic             blkRstOut
);
  logic softIdle;
  assign softIdle = (ctrlRd[1:0] == 2'b00) && (voteRd == '0);

  assert_status_legal_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlRd[31:28] == 4'h0) || (ctrlRd[31:28] == 4'h2) || (ctrlRd[31:28] == 4'h8));

  assert_status_off_R5: assert property (@(posedge clk) disable iff (!rstN)
    $past(softIdle) |=> (ctrlRd[31:28] == 4'h8));

  assert_vote_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == 2'd1) |=> (voteRd == $past(wrData[NMAST-1:0])));

  assert_div_reject_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == 2'd0 && int'(wrData[24:16]) > MAXDIV)
      |=> (ctrlRd[24:16] == $past(ctrlRd[24:16])));

  assert_blk_reset_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == 2'd2) |=> (blkRstOut == $past(wrData[0])));
endmodule

bind branch_gate branch_gate_chk #(.NMAST(NMAST), .MAXDIV(MAXDIV)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
  .ctrlRd(ctrlRd), .voteRd(voteRd), .blkRstOut(blkRstOut)
);

// File: tb/branch_gate_test.sv
module branch_gate_test;
  localparam int NMAST  = 4;
  localparam int MAXDIV = 15;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrSel = 2'd0;
  logic [31:0] wrData = '0;
  logic hwReq = 1'b0;
  logic gclkOut;
  logic [31:0] ctrlRd;
  logic [NMAST-1:0] voteRd;
  logic blkRstOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference model state
  int mEn = 0, mHw = 0, mDiv = 0, mVote = 0, mBlk = 0, mCnt = 0;
  int lastCode = 8;
  int expGclk = 0, expStat = 8;
  string gTag = "R1";

  branch_gate #(.NMAST(NMAST), .MAXDIV(MAXDIV)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .hwReq(hwReq), .gclkOut(gclkOut), .ctrlRd(ctrlRd), .voteRd(voteRd),
    .blkRstOut(blkRstOut)
  );

  always #5 clk = ~clk;

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int reqCode(int hwIn);
    if (mEn != 0 || mVote != 0) return 0;
    if (mHw != 0 && hwIn != 0) return 2;
    return 8;
  endfunction

  // model update and comparison on every rising edge
  always @(posedge clk) begin
    if (rstN) begin
      int code;
      int req;
      code = reqCode(int'(hwReq));
      req  = (code != 8);
      expGclk = (req != 0 && mCnt == 0);
      if (mDiv != 0) gTag = "R6";
      else if (code == 2) gTag = "R4";
      else if (mVote != 0 && mEn == 0) gTag = "R3";
      else gTag = "R2";
      expStat = lastCode;
      lastCode = code;
      if (!req) mCnt = 0;
      else if (mCnt >= mDiv) mCnt = 0;
      else mCnt = mCnt + 1;
      if (wrEn) begin
        if (wrSel == 2'd0) begin
          mEn = int'(wrData[0]);
          mHw = int'(wrData[1]);
          if (int'(wrData[24:16]) <= MAXDIV) mDiv = int'(wrData[24:16]);
        end else if (wrSel == 2'd1) mVote = int'(wrData[NMAST-1:0]);
        else if (wrSel == 2'd2) mBlk = int'(wrData[0]);
      end
      #2;
      check(gTag, "gclk high phase", int'(gclkOut), expGclk);
      check("R5", "status", int'(ctrlRd[31:28]), expStat);
      check("R7", "divider field", int'(ctrlRd[24:16]), mDiv);
      check("R2", "control bits", int'(ctrlRd[1:0]), mEn + 2*mHw);
      check("R3", "vote readback", int'(voteRd), mVote);
      check("R8", "block reset", int'(blkRstOut), mBlk);
    end
  end

  always @(negedge clk) begin
    #2;
    if (rstN) check("R9", "gclk in low phase", int'(gclkOut), 0);
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] sel, logic [31:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          failures++;
          checks++;
          $display("FAIL watchdog expired");
          $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
          $finish;
        end
      end
    join_none

    idle(3);
    // R1: reset state
    check("R1", "reset status", int'(ctrlRd[31:28]), 8);
    check("R1", "reset control", int'(ctrlRd[27:0]), 0);
    check("R1", "reset vote", int'(voteRd), 0);
    check("R1", "reset blk", int'(blkRstOut), 0);
    check("R1", "reset gclk", int'(gclkOut), 0);
    @(negedge clk) rstN = 1'b1;
    idle(3);

    wr(2'd0, 32'h1);                  idle(5);   // R2
    wr(2'd0, 32'h1 | (32'd2 << 16));  idle(9);   // R6 divide
    wr(2'd0, 32'h1 | (32'd20 << 16)); idle(4);   // R7 reject
    wr(2'd0, 32'h0);                  idle(4);
    wr(2'd1, 32'h4);                  idle(5);   // R3
    wr(2'd1, 32'h0);                  idle(4);
    wr(2'd0, 32'h0);
    hwReq = 1'b1;                     idle(4);   // R4: no effect without control
    wr(2'd0, 32'h2);                  idle(5);   // R4, status 2
    hwReq = 1'b0;                     idle(4);
    hwReq = 1'b1;                     idle(3);
    wr(2'd1, 32'h1);                  idle(4);   // R5 status 0
    wr(2'd1, 32'h0);
    hwReq = 1'b0;
    wr(2'd0, 32'h0);                  idle(4);
    wr(2'd0, 32'h1 | (32'd15 << 16)); idle(34);  // R6 max divide
    wr(2'd0, 32'h1 | (32'd16 << 16)); idle(4);   // R7 boundary
    wr(2'd0, 32'h0);                  idle(4);
    wr(2'd2, 32'h1);                  idle(3);   // R8
    wr(2'd2, 32'h0);                  idle(3);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule